// File: doc/BRIEF.md
# HDB3/AMI Line Encoder

This block turns a serial unipolar NRZ bit stream into two unipolar return-to-zero pulse streams, one carrying positive marks and one carrying negative marks. Logic outside the block sums the two streams into a three-level line signal. A mode input chooses between two codings. With the input low, the block does plain alternate-mark-inversion (AMI) coding. With it high, the block also does HDB3 zero-run substitution.

In HDB3 mode, every run of four zeros is replaced by either `000V` or `B00V`. V is a mark that deliberately repeats the polarity of the mark before it. B is a balancing mark that does obey alternation. The encoder picks B whenever the most recent mark has the same polarity as the most recent violation, which also covers the case where that mark was itself the violation. As a result, consecutive violations alternate in sign and the line keeps no DC offset.

Input bits are captured on the falling clock edge and pass through a 4-bit lookahead window. Each coded symbol is launched on a rising edge exactly 3.5 clock periods after its bit was captured. The pulse is high only for the first half of its bit period.

Top module: `hdb3_line_enc`

## Requirements
- R1: A bit captured on the falling edge at time t is sent as its line symbol from the rising edge at t + 3.5 clock periods. After reset is released, the first bit captured appears on the fourth rising edge.
- R2: Outside substituted runs, a zero is sent as a space and a one is sent as a mark whose polarity is opposite to that of the previous mark. A positive mark drives `line_pos`, a negative mark drives `line_neg`, and a space drives neither.
- R3: In HDB3 mode (`hdb_mode` = 1), for each run of four zeros not already inside a substitution, the 2nd and 3rd positions are spaces. The 4th position is a violation mark with the same polarity as the previous mark. A run of eight zeros produces two such groups.
- R4: In HDB3 mode, the 1st position of a substituted run is a space if the previous mark differs in polarity from the previous violation. Otherwise it is a balancing mark of polarity opposite to the previous mark.
- R5: In AMI mode (`hdb_mode` = 0), zero runs of any length are sent as spaces, and every one is an alternating mark.
- R6: Each output is high at most during the high half of the clock, and is low during the low half.
- R7: While `rst` is high, and until the first captured bit reaches the output, both outputs are low. After reset, the previous mark and the previous violation are both taken as negative, so a stream that starts with four zeros is sent as B+, space, space, V+.
- R8: `line_pos` and `line_neg` are never high in the same bit period.
- R9: In HDB3 mode, each violation has the opposite polarity to the previous violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; data captured on the falling edge, symbols launched on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hdb_mode | input | 1 | 1 selects HDB3 with zero-run substitution, 0 selects plain AMI |
| nrz_in | input | 1 | Serial unipolar NRZ data |
| line_pos | output | 1 | Return-to-zero pulse for a positive mark |
| line_neg | output | 1 | Return-to-zero pulse for a negative mark |

## Verification
Within a single bit period, the substitution logic and the ordinary alternation logic can both try to claim a position. One case is a one arriving just after a violation; another is a zero run beginning right where a previous run's violation was emitted. The stimulus provokes these overlaps with back-to-back zero runs of eight and twelve bits, ones directly adjacent to zero runs, and a long sparse pseudo-random stream. Each output period is judged against a reference encoder in the bench that counts marks since the last violation to choose between B00V and 000V. That rule is phrased differently from the polarity comparison used in the design.

// File: rtl/hdb3_pkg.sv
`timescale 1ns/1ps
package hdb3_pkg;

    // One coded line position.
    typedef struct packed {
        logic mark;   // a pulse is sent in this position
        logic pol;    // 1 = positive, 0 = negative
        logic viol;   // pulse breaks the alternation rule
    } pulse_t;

    localparam logic POL_NEG = 1'b0;
    localparam logic POL_POS = 1'b1;

    localparam pulse_t PULSE_SPACE = '{mark: 1'b0, pol: 1'b0, viol: 1'b0};

    function automatic pulse_t make_mark(input logic pol, input logic viol);
        pulse_t p;
        p.mark = 1'b1;
        p.pol  = pol;
        p.viol = viol;
        return p;
    endfunction

endpackage

// File: rtl/hdb3_window.sv
`timescale 1ns/1ps
module hdb3_window #(
    parameter int RUN_LEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nrz_i,
    output logic [RUN_LEN-1:0] win_o,
    output logic               cur_valid_o
);
    localparam int DEPTH = RUN_LEN - 1;

    logic             cap_q;
    logic             cap_v;
    logic [DEPTH-1:0] sh_d;
    logic [DEPTH-1:0] sh_v;

    // Input capture on the falling edge, centred in the bit.
    always_ff @(negedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
            cap_v <= 1'b0;
        end else begin
            cap_q <= nrz_i;
            cap_v <= 1'b1;
        end
    end

    // Delay line on the rising edge; the oldest stage is the bit being coded.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_d <= '0;
            sh_v <= '0;
        end else begin
            sh_d <= {sh_d[DEPTH-2:0], cap_q};
            sh_v <= {sh_v[DEPTH-2:0], cap_v};
        end
    end

    // win_o[RUN_LEN-1] is the current bit, lower indices are lookahead.
    assign win_o       = {sh_d, cap_q};
    assign cur_valid_o = sh_v[DEPTH-1];

endmodule

// File: rtl/hdb3_subst.sv
`timescale 1ns/1ps
module hdb3_subst
    import hdb3_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hdb_mode_i,
    input  logic               cur_valid_i,
    input  logic [RUN_LEN-1:0] win_i,
    output pulse_t             sym_o
);
    localparam int CW = $clog2(RUN_LEN);
    localparam logic [CW-1:0] RUN_REST = CW'(RUN_LEN - 1);
    localparam logic [CW-1:0] LAST_POS = CW'(1);

    logic          last_pol_q;   // polarity of the previous mark
    logic          viol_pol_q;   // polarity of the previous violation
    logic [CW-1:0] left_q;       // positions still owed to a substitution
    logic [CW-1:0] left_d;
    pulse_t        sym;

    always_comb begin
        sym    = PULSE_SPACE;
        left_d = left_q;
        if (left_q != '0) begin
            left_d = left_q - LAST_POS;
            if (left_q == LAST_POS) begin
                sym = make_mark(last_pol_q, 1'b1);
            end
        end else if (win_i[RUN_LEN-1]) begin
            sym = make_mark(!last_pol_q, 1'b0);
        end else if (hdb_mode_i && (win_i == '0)) begin
            left_d = RUN_REST;
            if (last_pol_q == viol_pol_q) begin
                sym = make_mark(!last_pol_q, 1'b0);
            end
        end
        if (!cur_valid_i) begin
            sym    = PULSE_SPACE;
            left_d = left_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pol_q <= POL_NEG;
            viol_pol_q <= POL_NEG;
            left_q     <= '0;
        end else if (cur_valid_i) begin
            left_q <= left_d;
            if (sym.mark) last_pol_q <= sym.pol;
            if (sym.viol) viol_pol_q <= sym.pol;
        end
    end

    assign sym_o = sym;

    // R9: a violation never repeats the sign of the one before it
    p_viol_alt_r9: assert property (@(posedge clk) disable iff (rst)
        (cur_valid_i && sym.viol) |-> (sym.pol != viol_pol_q));

    // R3: once a run is claimed, the next bit entering the coder is a zero
    p_run_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (cur_valid_i && (left_q == RUN_REST)) |-> !win_i[RUN_LEN-1]);

    // R5: in AMI mode a mark is sent exactly for a one
    p_ami_plain_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_valid_i && !hdb_mode_i && (left_q == '0)) |-> (sym.mark == win_i[RUN_LEN-1]));

endmodule

// File: rtl/hdb3_rz.sv
`timescale 1ns/1ps
module hdb3_rz
    import hdb3_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  pulse_t           sym_i,
    output logic [LANES-1:0] held_o,
    output logic             line_pos_o,
    output logic             line_neg_o
);
    // Lane 0 carries positive marks, lane 1 negative marks.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic LANE_POL = (l == 0) ? POL_POS : POL_NEG;
        logic lane_q;
        always_ff @(posedge clk) begin
            if (rst) lane_q <= 1'b0;
            else     lane_q <= valid_i && sym_i.mark && (sym_i.pol == LANE_POL);
        end
        assign held_o[l] = lane_q;
    end

    // Return to zero for the low half of each period.
    assign line_pos_o = held_o[0] & clk;
    assign line_neg_o = held_o[1] & clk;

    // R8: both polarities are never held in one period
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(held_o[0] && held_o[1]));

endmodule

// File: rtl/hdb3_line_enc.sv
`timescale 1ns/1ps
module hdb3_line_enc
    import hdb3_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hdb_mode,
    input  logic nrz_in,
    output logic line_pos,
    output logic line_neg
);
    logic [RUN_LEN-1:0] win;
    logic               cur_valid;
    pulse_t             sym;
    logic [1:0]         held;

    hdb3_window #(.RUN_LEN(RUN_LEN)) u_window (
        .clk         (clk),
        .rst         (rst),
        .nrz_i       (nrz_in),
        .win_o       (win),
        .cur_valid_o (cur_valid)
    );

    hdb3_subst #(.RUN_LEN(RUN_LEN)) u_subst (
        .clk         (clk),
        .rst         (rst),
        .hdb_mode_i  (hdb_mode),
        .cur_valid_i (cur_valid),
        .win_i       (win),
        .sym_o       (sym)
    );

    hdb3_rz #(.LANES(2)) u_rz (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (cur_valid),
        .sym_i      (sym),
        .held_o     (held),
        .line_pos_o (line_pos),
        .line_neg_o (line_neg)
    );

    // R7: nothing is launched before the window has filled
    p_fill_r7: assert property (@(posedge clk) disable iff (rst)
        !cur_valid |=> (held == 2'b00));

endmodule

// File: tb/hdb3_line_enc_test.sv
`timescale 1ns/1ps
module hdb3_line_enc_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hdb_mode = 1'b1;
    logic nrz_in = 1'b0;
    logic line_pos;
    logic line_neg;

    always #2 clk = ~clk;

    hdb3_line_enc uut (
        .clk      (clk),
        .rst      (rst),
        .hdb_mode (hdb_mode),
        .nrz_in   (nrz_in),
        .line_pos (line_pos),
        .line_neg (line_neg)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    int    stim[$];
    int    xs[];
    int    expv[];
    string tags[];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int ex);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, ex, $time);
        end
    endtask

    function automatic int obs();
        if (line_pos && line_neg) return 2;
        if (line_pos) return 1;
        if (line_neg) return -1;
        return 0;
    endfunction

    task automatic load_str(input string s);
        stim.delete();
        for (int i = 0; i < s.len(); i++) begin
            if (s[i] == "1") stim.push_back(1);
            else if (s[i] == "0") stim.push_back(0);
        end
    endtask

    // Reference: parity of marks since the last violation picks B00V or 000V.
    task automatic build(input bit hdb);
        int n;
        int pol;
        int nm;
        int zr;
        n = stim.size();
        xs = new[n + 4];
        expv = new[n + 4];
        tags = new[n + 4];
        for (int i = 0; i < n + 4; i++) xs[i] = (i < n) ? stim[i] : 0;
        pol = -1; nm = 0; zr = 0;
        for (int i = 0; i < n + 4; i++) begin
            tags[i] = hdb ? "R2" : "R5";
            if (xs[i] != 0) begin
                pol = -pol; expv[i] = pol; nm++; zr = 0;
            end else begin
                expv[i] = 0; zr++;
                if (hdb && zr == 4) begin
                    if (nm % 2 == 0) begin
                        pol = -pol; expv[i-3] = pol;
                    end
                    tags[i-3] = "R4";
                    tags[i-2] = "R3";
                    tags[i-1] = "R3";
                    expv[i] = pol;
                    tags[i] = "R3";
                    nm = 0; zr = 0;
                end
            end
        end
    endtask

    task automatic run_seg(input bit hdb);
        int n;
        int last_obs;
        int last_v;
        build(hdb);
        n = stim.size();
        @(posedge clk); #1;
        rst = 1'b1; hdb_mode = hdb; nrz_in = 1'b0;
        repeat (3) begin
            @(posedge clk); #1;
            check(!line_pos && !line_neg, "R7", "outputs in reset", obs(), 0);
        end
        rst = 1'b0;
        last_obs = -1; last_v = -1;
        for (int c = 0; c < n + 4; c++) begin
            int k;
            int ex;
            int o;
            string tg;
            nrz_in = xs[c][0];
            k = c - 4;
            o = obs();
            if (k < n) begin
                ex = (k >= 0) ? expv[k] : 0;
                tg = (k < 0) ? "R7" : ((k == 0) ? "R1" : tags[k]);
                check(o == ex, tg, "line symbol", o, ex);
            end
            check(!(line_pos && line_neg), "R8", "both outputs high", o, 0);
            if (hdb && k >= 0 && k < n && (o == 1 || o == -1)) begin
                if (o == last_obs) begin
                    check(o != last_v, "R9", "violation polarity", o, -last_v);
                    last_v = o;
                end
                last_obs = o;
            end
            @(negedge clk); #1;
            check(!line_pos && !line_neg, "R6", "low half of period", obs(), 0);
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        int unsigned lf;
        // Directed HDB3: start-up B00V, both substitution forms, long runs, short runs.
        load_str("0000_1_0000_11_0000_00000000_1_000_1_000000000000_00_1_0_1111_0000_1_0");
        run_seg(1'b1);
        // AMI: no substitution for any run length.
        load_str("0000_1_0000_11_00000000_1_000_1_111_0000000000_1_0");
        run_seg(1'b0);
        // Dense ones followed by a long zero stretch.
        load_str("11111111111111111111_000000000000000000000_1");
        run_seg(1'b1);
        // Sparse pseudo-random HDB3 stream.
        stim.delete();
        lf = 32'hACE1_2357;
        for (int i = 0; i < 400; i++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            stim.push_back(((lf & 32'd3) == 32'd3) ? 1 : 0);
        end
        run_seg(1'b1);
        done = 1;
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            finish_up();
        end
    end

endmodule